// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block holds the pending interrupt requests of a processor core and, whenever the core opens a sampling point, chooses the one request the core accepts. Two kinds of source feed it. There is a group of maskable peripheral lines, each ranked by a programmable 3-bit level. There are also six special sources whose rank is fixed in hardware. A maskable request can win only when its level is strictly above the core's current interrupt priority level (IPL) and the global enable is set. Ties between equal levels go to the lower line index.

A source is raised by a one-cycle pulse on its set input. It then stays pending until it is accepted. The result leaves the block as a registered one-cycle accept strobe, together with the winning source number and its level. The accepted source's pending bit is cleared on that same edge. Updates to a line's level and to the IPL do not reach the decision at once. A level write and an IPL load from a return-from-interrupt act after two cycles. An IPL load from a pop or a control-register load acts after three cycles.

Top module: `irq_arbiter`

## Requirements
- R1: A level value of 0 disables a maskable line; values 1 to 7 rank it, with 7 the most urgent. After reset every line's level is 0 and the IPL is 0.
- R2: A pending maskable line is a candidate only when its level is strictly greater than the effective IPL. An IPL of 7 blocks every maskable line, and a level equal to the IPL is refused.
- R3: Among candidate maskable lines, the one with the highest level wins, whatever its index.
- R4: Among candidate maskable lines of equal level, the lowest index wins.
- R5: Source numbers and their fixed rank, from highest to lowest, are: 0 reset, 1 NMI, 2 debug, 3 watchdog, then maskable line i as 4+i, then single-step as N_IRQ+4 and address match as N_IRQ+5. On `spec_set`, bits 0 to 5 raise reset, NMI, debug, watchdog, single-step and address match, in that order.
- R6: The global enable `gie` gates only maskable lines. Special sources are accepted with `gie` low. A maskable line blocked by `gie` stays pending.
- R7: When `sample` is high in cycle c and any source is eligible, `acc` is high in cycle c+1 for one cycle. In that cycle `acc_src` holds the winner's number and `acc_lvl` holds its level. The winner's pending bit is cleared at that edge, unless its set pulse arrives in cycle c, in which case it stays pending.
- R8: A level written in cycle k is ignored by a sample in cycle k+1 and used by samples from cycle k+2 on.
- R9: An IPL written with `ipl_wr_kind`=0 (return-from-interrupt) in cycle k is used by samples from cycle k+2 on.
- R10: An IPL written with `ipl_wr_kind`=1 (pop or register load) in cycle k is ignored by samples in cycles k+1 and k+2 and used from k+3 on. When two pending IPL writes mature in the same cycle, the later-issued one wins.
- R11: Level writes, IPL writes and `gie` changes never alter pending bits. A level write alters no other line's level.
- R12: When `acc` is low, `acc_src` and `acc_lvl` are 0. A special source is reported with `acc_lvl` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | Sampling point: arbitrate the pending set this cycle |
| gie | input | 1 | Global enable for maskable lines |
| irq_set | input | N_IRQ | One-cycle set pulses for maskable lines |
| spec_set | input | 6 | One-cycle set pulses for special sources (R5 order) |
| lvl_wr_en | input | 1 | Level write strobe |
| lvl_wr_idx | input | IDX_W | Line index for the level write |
| lvl_wr_val | input | 3 | New level |
| ipl_wr_en | input | 1 | IPL write strobe |
| ipl_wr_kind | input | 1 | 0 = return-from-interrupt load, 1 = pop or register load |
| ipl_wr_val | input | 3 | New IPL |
| acc | output | 1 | Accept strobe |
| acc_src | output | SRC_W | Winning source number |
| acc_lvl | output | 3 | Winning level (0 for special sources) |

## Verification
The hardest situation to reach from the ports is two IPL writes of different kinds in flight at once. This happens when a three-cycle load is followed one cycle later by a two-cycle return-from-interrupt load, so that both mature on the same edge. The stimulus issues the two writes on back-to-back cycles in both orders while a level-3 request is held pending. The order of the writes then decides whether that request is accepted once the writes have settled. The two-cycle level delay and the two IPL delays are probed the same way: a request is held pending and sampled in each cycle right after the write, so the exact first cycle that sees the new value is pinned down in both directions (enabling and disabling).

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W     = 3;
    localparam int ID_W      = 8;
    localparam int N_SPEC    = 6;
    localparam int N_SPEC_HI = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        SP_RESET  = 3'd0,
        SP_NMI    = 3'd1,
        SP_DEBUG  = 3'd2,
        SP_WDOG   = 3'd3,
        SP_STEP   = 3'd4,
        SP_AMATCH = 3'd5
    } spec_e;

    typedef enum logic {
        IPL_RET  = 1'b0,
        IPL_LOAD = 1'b1
    } ipl_kind_e;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] src;
        lvl_t            lvl;
    } pick_t;

    typedef struct packed {
        logic            v;
        logic [ID_W-1:0] idx;
        lvl_t            val;
    } lvl_wr_t;

    typedef struct packed {
        logic v;
        lvl_t val;
    } ipl_slot_t;

    function automatic logic [ID_W-1:0] low_spec_id(input int n_irq, input spec_e s);
        return (s == SP_STEP)   ? ID_W'(n_irq + N_SPEC_HI) :
               (s == SP_AMATCH) ? ID_W'(n_irq + N_SPEC_HI + 1) :
                                  ID_W'(s);
    endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_all,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_id,
    output logic [NSRC-1:0] pend_all
);

    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) begin
            clr_mask = NSRC'(1) << clr_id;
        end
    end

    // a fresh set pulse outranks the clear of the same source
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_all <= '0;
        end else begin
            pend_all <= (pend_all & ~clr_mask) | set_all;
        end
    end

endmodule

// File: rtl/irq_lvl_pipe.sv
module irq_lvl_pipe
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DLY   = 2,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int NSTG  = DLY - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  lvl_t             wr_val,
    output lvl_t             lvl_eff [N_IRQ]
);

    lvl_wr_t stg [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NSTG; j++) begin
                stg[j] <= '0;
            end
        end else begin
            stg[0] <= '{v: wr_en, idx: ID_W'(wr_idx), val: wr_val};
            for (int j = 1; j < NSTG; j++) begin
                stg[j] <= stg[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_IRQ; i++) begin
                lvl_eff[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (stg[NSTG-1].v && (int'(stg[NSTG-1].idx) == i)) begin
                    lvl_eff[i] <= stg[NSTG-1].val;
                end
            end
        end
    end

endmodule

// File: rtl/irq_ipl_pipe.sv
module irq_ipl_pipe
    import irq_arb_pkg::*;
#(
    parameter int DLY_RET  = 2,
    parameter int DLY_LOAD = 3,
    localparam int NSLOT     = DLY_LOAD - 1,
    localparam int ENTRY_RET = DLY_LOAD - DLY_RET
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  ipl_kind_e wr_kind,
    input  lvl_t      wr_val,
    output lvl_t      ipl_eff
);

    ipl_slot_t slot [NSLOT];
    logic      enter_load;
    logic      enter_ret;

    assign enter_load = wr_en && (wr_kind == IPL_LOAD);
    assign enter_ret  = wr_en && (wr_kind == IPL_RET);

    // the shorter path joins the shared line part way along; a write entering a
    // slot displaces the older write shifting into it, so the later issue wins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NSLOT; j++) begin
                slot[j] <= '0;
            end
        end else begin
            if (enter_load || (enter_ret && ENTRY_RET == 0)) begin
                slot[0] <= '{v: 1'b1, val: wr_val};
            end else begin
                slot[0] <= '0;
            end
            for (int j = 1; j < NSLOT; j++) begin
                if (enter_ret && (j == ENTRY_RET)) begin
                    slot[j] <= '{v: 1'b1, val: wr_val};
                end else begin
                    slot[j] <= slot[j-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl_eff <= '0;
        end else if (slot[NSLOT-1].v) begin
            ipl_eff <= slot[NSLOT-1].val;
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int NSRC = N_IRQ + N_SPEC
) (
    input  logic [NSRC-1:0] pend_all,
    input  lvl_t            lvl_eff [N_IRQ],
    input  lvl_t            ipl,
    input  logic            gie,
    output pick_t           win
);

    logic            m_hit;
    lvl_t            m_lvl;
    logic [ID_W-1:0] m_id;

    // descending scan with >= leaves the lowest index holding a tie
    always_comb begin
        m_hit = 1'b0;
        m_lvl = '0;
        m_id  = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (gie && pend_all[N_SPEC_HI + i] && (lvl_eff[i] > ipl) && (lvl_eff[i] >= m_lvl)) begin
                m_hit = 1'b1;
                m_lvl = lvl_eff[i];
                m_id  = ID_W'(N_SPEC_HI + i);
            end
        end
    end

    always_comb begin
        win = '0;
        if (pend_all[SP_RESET]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_RESET), lvl: '0};
        end else if (pend_all[SP_NMI]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_NMI), lvl: '0};
        end else if (pend_all[SP_DEBUG]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_DEBUG), lvl: '0};
        end else if (pend_all[SP_WDOG]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_WDOG), lvl: '0};
        end else if (m_hit) begin
            win = '{found: 1'b1, src: m_id, lvl: m_lvl};
        end else if (pend_all[N_IRQ + N_SPEC_HI]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_STEP), lvl: '0};
        end else if (pend_all[N_IRQ + N_SPEC_HI + 1]) begin
            win = '{found: 1'b1, src: low_spec_id(N_IRQ, SP_AMATCH), lvl: '0};
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ        = 8,
    parameter int LVL_DLY      = 2,
    parameter int IPL_DLY_RET  = 2,
    parameter int IPL_DLY_LOAD = 3,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int NSRC  = N_IRQ + N_SPEC,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              gie,
    input  logic [N_IRQ-1:0]  irq_set,
    input  logic [N_SPEC-1:0] spec_set,
    input  logic              lvl_wr_en,
    input  logic [IDX_W-1:0]  lvl_wr_idx,
    input  logic [LVL_W-1:0]  lvl_wr_val,
    input  logic              ipl_wr_en,
    input  logic              ipl_wr_kind,
    input  logic [LVL_W-1:0]  ipl_wr_val,
    output logic              acc,
    output logic [SRC_W-1:0]  acc_src,
    output logic [LVL_W-1:0]  acc_lvl
);

    logic [NSRC-1:0] set_all;
    logic [NSRC-1:0] pend_all;
    lvl_t            lvl_eff [N_IRQ];
    lvl_t            ipl_eff;
    pick_t           win;
    logic            grant;

    // source numbering puts the maskable group between the two special bands
    assign set_all = {spec_set[SP_AMATCH], spec_set[SP_STEP], irq_set, spec_set[N_SPEC_HI-1:0]};

    irq_pend #(.NSRC(NSRC)) pend_i (
        .clk      (clk),
        .rst      (rst),
        .set_all  (set_all),
        .clr_en   (grant),
        .clr_id   (win.src),
        .pend_all (pend_all)
    );

    irq_lvl_pipe #(.N_IRQ(N_IRQ), .DLY(LVL_DLY)) lvl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lvl_wr_en),
        .wr_idx  (lvl_wr_idx),
        .wr_val  (lvl_wr_val),
        .lvl_eff (lvl_eff)
    );

    irq_ipl_pipe #(.DLY_RET(IPL_DLY_RET), .DLY_LOAD(IPL_DLY_LOAD)) ipl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ipl_wr_en),
        .wr_kind (ipl_kind_e'(ipl_wr_kind)),
        .wr_val  (ipl_wr_val),
        .ipl_eff (ipl_eff)
    );

    irq_pick #(.N_IRQ(N_IRQ)) pick_i (
        .pend_all (pend_all),
        .lvl_eff  (lvl_eff),
        .ipl      (ipl_eff),
        .gie      (gie),
        .win      (win)
    );

    assign grant = sample && win.found;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= 1'b0;
            acc_src <= '0;
            acc_lvl <= '0;
        end else begin
            acc     <= grant;
            acc_src <= grant ? win.src[SRC_W-1:0] : '0;
            acc_lvl <= grant ? win.lvl : '0;
        end
    end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int NSRC  = N_IRQ + N_SPEC,
    localparam int SRC_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst,
    input logic             sample,
    input logic             gie,
    input logic             acc,
    input logic [SRC_W-1:0] acc_src,
    input logic [LVL_W-1:0] acc_lvl,
    input logic [NSRC-1:0]  pend_all,
    input logic [NSRC-1:0]  set_all,
    input logic [LVL_W-1:0] ipl_eff
);

    logic            is_mask;
    logic [NSRC-1:0] set_q;

    assign is_mask = (int'(acc_src) >= N_SPEC_HI) && (int'(acc_src) < N_SPEC_HI + N_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
        end else begin
            set_q <= set_all;
        end
    end

    AST_STROBE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        acc |-> $past(sample)); // R7

    AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (acc && !set_q[acc_src]) |-> !pend_all[acc_src]); // R7

    AST_MASK_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
        (acc && is_mask) |-> (acc_lvl > $past(ipl_eff))); // R2

    AST_MASK_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        (acc && is_mask) |-> $past(gie)); // R6

    AST_RESET_SRC_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($past(sample) && $past(pend_all[0])) |-> (acc && acc_src == '0)); // R5

    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc |-> (int'(acc_src) < NSRC)); // R5

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !acc |-> (acc_src == '0 && acc_lvl == '0)); // R12

    AST_SPECIAL_LVL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_mask) |-> (acc_lvl == '0)); // R12

endmodule

bind irq_arbiter irq_arbiter_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .gie      (gie),
    .acc      (acc),
    .acc_src  (acc_src),
    .acc_lvl  (acc_lvl),
    .pend_all (pend_all),
    .set_all  (set_all),
    .ipl_eff  (ipl_eff)
);

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N     = 8;
    localparam int IDX_W = 3;
    localparam int NSRC  = N + 6;
    localparam int SRC_W = 4;
    localparam int ID_STEP = N + 4;
    localparam int ID_AM   = N + 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sample = 1'b0;
    logic             gie = 1'b1;
    logic [N-1:0]     irq_set = '0;
    logic [5:0]       spec_set = '0;
    logic             lvl_wr_en = 1'b0;
    logic [IDX_W-1:0] lvl_wr_idx = '0;
    logic [2:0]       lvl_wr_val = '0;
    logic             ipl_wr_en = 1'b0;
    logic             ipl_wr_kind = 1'b0;
    logic [2:0]       ipl_wr_val = '0;
    logic             acc;
    logic [SRC_W-1:0] acc_src;
    logic [2:0]       acc_lvl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int          m_lvl [N];
    int          m_ipl;
    bit [NSRC-1:0] mp;

    always #2.5 clk = ~clk;

    irq_arbiter #(.N_IRQ(N)) dut_i (
        .clk(clk), .rst(rst), .sample(sample), .gie(gie),
        .irq_set(irq_set), .spec_set(spec_set),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx), .lvl_wr_val(lvl_wr_val),
        .ipl_wr_en(ipl_wr_en), .ipl_wr_kind(ipl_wr_kind), .ipl_wr_val(ipl_wr_val),
        .acc(acc), .acc_src(acc_src), .acc_lvl(acc_lvl)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sample_expect(bit f, int src, int lvl, string tag);
        sample = 1'b1;
        tick();
        sample = 1'b0;
        check({tag, " acc"}, int'(acc), int'(f));
        if (f) begin
            check({tag, " src"}, int'(acc_src), src);
            check({tag, " lvl"}, int'(acc_lvl), lvl);
            mp[src] = 1'b0;
        end
    endtask

    task automatic set_lvl(int idx, int val);
        lvl_wr_en = 1'b1; lvl_wr_idx = IDX_W'(idx); lvl_wr_val = 3'(val);
        tick();
        lvl_wr_en = 1'b0;
        tick();
        m_lvl[idx] = val;
    endtask

    task automatic ipl_write(bit kind, int val);
        ipl_wr_en = 1'b1; ipl_wr_kind = kind; ipl_wr_val = 3'(val);
        tick();
        ipl_wr_en = 1'b0;
    endtask

    task automatic set_ipl(bit kind, int val);
        ipl_write(kind, val);
        tick();
        if (kind) tick();
        m_ipl = val;
    endtask

    task automatic raise(bit [N-1:0] im, bit [5:0] sm);
        irq_set = im; spec_set = sm;
        tick();
        irq_set = '0; spec_set = '0;
        mp = mp | {sm[5:4], im, sm[3:0]};
    endtask

    task automatic model_pick(output bit f, output int src, output int lvl);
        int bl;
        f = 0; src = 0; lvl = 0; bl = 0;
        for (int s = 0; s < 4; s++) begin
            if (!f && mp[s]) begin f = 1; src = s; end
        end
        if (!f && gie) begin
            for (int i = 0; i < N; i++) begin
                if (mp[4+i] && m_lvl[i] > m_ipl && m_lvl[i] > bl) begin
                    bl = m_lvl[i]; src = 4 + i; lvl = bl; f = 1;
                end
            end
        end
        if (!f && mp[ID_STEP]) begin f = 1; src = ID_STEP; end
        if (!f && mp[ID_AM])   begin f = 1; src = ID_AM; end
    endtask

    task automatic t_reset();
        check("R12 reset acc", int'(acc), 0);
        check("R12 reset src", int'(acc_src), 0);
        check("R12 reset lvl", int'(acc_lvl), 0);
        raise(8'h01, 6'h00);
        sample_expect(0, 0, 0, "R1 level 0 after reset");
        set_lvl(0, 1);
        sample_expect(1, 4, 1, "R1 level 1 over IPL 0");
    endtask

    task automatic t_levels();
        set_lvl(2, 3);
        set_ipl(1'b1, 3);
        raise(8'h04, 6'h00);
        sample_expect(0, 0, 0, "R2 level equal IPL");
        set_ipl(1'b0, 2);
        sample_expect(1, 6, 3, "R2 level above IPL");
        raise(8'h08, 6'h00);
        set_ipl(1'b1, 0);
        sample_expect(0, 0, 0, "R1 level 0 disabled");
        set_lvl(3, 7);
        set_ipl(1'b1, 7);
        sample_expect(0, 0, 0, "R2 IPL 7 blocks level 7");
        set_ipl(1'b0, 6);
        sample_expect(1, 7, 7, "R2 level 7 over IPL 6");
        set_ipl(1'b1, 0);
    endtask

    task automatic t_order();
        set_lvl(1, 4);
        set_lvl(5, 6);
        raise(8'h22, 6'h00);
        sample_expect(1, 9, 6, "R3 higher level first");
        sample_expect(1, 5, 4, "R3 lower level next");
        set_lvl(2, 5);
        set_lvl(6, 5);
        raise(8'h44, 6'h00);
        sample_expect(1, 6, 5, "R4 tie lower index");
        sample_expect(1, 10, 5, "R4 tie second");
    endtask

    task automatic t_special();
        set_lvl(0, 7);
        raise(8'h01, 6'h3F);
        sample_expect(1, 0, 0, "R5 reset");
        sample_expect(1, 1, 0, "R5 nmi");
        sample_expect(1, 2, 0, "R5 debug");
        sample_expect(1, 3, 0, "R5 watchdog");
        sample_expect(1, 4, 7, "R5 maskable");
        sample_expect(1, ID_STEP, 0, "R5 single-step");
        sample_expect(1, ID_AM, 0, "R5 address match");
        sample_expect(0, 0, 0, "R5 drained");
        gie = 1'b0;
        raise(8'h01, 6'h10);
        sample_expect(1, ID_STEP, 0, "R6 step with gie low");
        raise(8'h00, 6'h02);
        sample_expect(1, 1, 0, "R6 nmi with gie low");
        sample_expect(0, 0, 0, "R6 maskable held by gie");
        gie = 1'b1;
        sample_expect(1, 4, 7, "R6 maskable after gie");
    endtask

    task automatic t_strobe();
        set_lvl(4, 2);
        raise(8'h10, 6'h00);
        sample_expect(1, 8, 2, "R7 accept");
        tick();
        check("R7 strobe one cycle", int'(acc), 0);
        check("R12 idle src", int'(acc_src), 0);
        check("R12 idle lvl", int'(acc_lvl), 0);
        raise(8'h10, 6'h00);
        irq_set = 8'h10; sample = 1'b1;
        tick();
        irq_set = '0; sample = 1'b0;
        check("R7 accept during set", int'(acc_src), 8);
        sample_expect(1, 8, 2, "R7 set kept pending");
        sample_expect(0, 0, 0, "R7 cleared");
    endtask

    task automatic t_lvl_delay();
        set_lvl(3, 0);
        raise(8'h08, 6'h00);
        lvl_wr_en = 1'b1; lvl_wr_idx = 3'd3; lvl_wr_val = 3'd5;
        tick();
        lvl_wr_en = 1'b0;
        sample_expect(0, 0, 0, "R8 old level one cycle after");
        m_lvl[3] = 5;
        sample_expect(1, 7, 5, "R8 new level two cycles after");
        raise(8'h08, 6'h00);
        lvl_wr_en = 1'b1; lvl_wr_val = 3'd0;
        tick();
        lvl_wr_en = 1'b0;
        sample_expect(1, 7, 5, "R8 disable not yet seen");
        m_lvl[3] = 0;
    endtask

    task automatic t_ipl_delay();
        set_lvl(0, 3);
        set_ipl(1'b1, 5);
        raise(8'h01, 6'h00);
        ipl_write(1'b0, 1);
        sample_expect(0, 0, 0, "R9 return load k+1");
        sample_expect(1, 4, 3, "R9 return load k+2");
        set_ipl(1'b1, 5);
        raise(8'h01, 6'h00);
        ipl_write(1'b1, 1);
        sample_expect(0, 0, 0, "R10 register load k+1");
        sample_expect(0, 0, 0, "R10 register load k+2");
        sample_expect(1, 4, 3, "R10 register load k+3");
        raise(8'h01, 6'h00);
        ipl_write(1'b1, 6);
        ipl_write(1'b0, 2);
        tick(); tick(); tick();
        m_ipl = 2;
        sample_expect(1, 4, 3, "R10 collision later return wins");
        raise(8'h01, 6'h00);
        ipl_write(1'b0, 1);
        ipl_write(1'b1, 6);
        tick(); tick(); tick();
        m_ipl = 6;
        sample_expect(0, 0, 0, "R10 later load wins");
        set_ipl(1'b0, 0);
        sample_expect(1, 4, 3, "R10 released");
    endtask

    task automatic t_indep();
        set_ipl(1'b1, 7);
        set_lvl(1, 2);
        raise(8'h02, 6'h00);
        sample_expect(0, 0, 0, "R11 blocked by IPL");
        set_lvl(1, 3);
        gie = 1'b0; tick(); gie = 1'b1;
        set_ipl(1'b0, 0);
        sample_expect(1, 5, 3, "R11 pending survives writes");
        raise(8'h20, 6'h00);
        sample_expect(1, 9, 6, "R11 other level untouched");
    endtask

    task automatic t_random();
        bit f; int src; int lvl;
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0) set_lvl(int'($urandom_range(0, N-1)), int'($urandom_range(0, 7)));
            if ($urandom_range(0, 5) == 0) set_ipl(1'($urandom_range(0, 1)), int'($urandom_range(0, 6)));
            gie = ($urandom_range(0, 4) != 0);
            raise(N'($urandom), ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h00);
            model_pick(f, src, lvl);
            sample_expect(f, src, lvl, "R3 R4 R5 R6 model");
        end
        gie = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_lvl[i] = 0;
        m_ipl = 0;
        mp = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_levels();
        t_order();
        t_special();
        t_strobe();
        t_lvl_delay();
        t_ipl_delay();
        t_indep();
        t_random();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule